// File: doc/BRIEF.md
# Outstanding-Request Latency Accumulator

This block measures the average latency of link requests without tagging individual requests. It keeps a live count of requests in flight. On every enabled clock it adds that count to a wide accumulator, so the accumulator ends up holding the total number of cycles that all requests spent outstanding. A second counter records accepted issues, and a third counts enabled cycles. Software divides the accumulator by the issue count to get the mean latency in cycles. It compares the cycle count with wall-clock time to find the link frequency.

One instance serves one direction and one kind of traffic. A chip places four instances: incoming reads, incoming writes, outgoing reads and outgoing writes. When the far end of the link is another chip rather than a GPU, only reads are tracked, so the write instances fall idle. When GPUs are attached, a per-GPU select mask limits tracking to chosen GPUs. Each strobe carries the index of the GPU it belongs to.

Top module: `outstanding_lat_acc`

## Requirements
- R1: After reset, `req_count`, `cum_outs`, `cycle_count` and `in_flight` are 0 and `seq_err` is 0.
- R2: An accepted `issue` raises `in_flight` by 1 at the next edge. An accepted `done` lowers it by 1. Both accepted in the same cycle leave it unchanged, with no error even at zero.
- R3: On each counting cycle, `cum_outs` grows by the value `in_flight` held before that edge. A single request whose `done` strobe comes N edges after its `issue` strobe therefore adds exactly N.
- R4: `req_count` grows by 1 for each issue accepted in a counting cycle.
- R5: `cycle_count` grows by 1 for every counting cycle.
- R6: A counting cycle is one where `enable` is 1 and the instance is active. With `enable` at 0, `req_count`, `cum_outs` and `cycle_count` all hold. `in_flight` still follows issues and completions.
- R7: A `done` with `in_flight` at 0 and no issue in the same cycle is ignored. It sets `seq_err`, which stays at 1 until reset.
- R8: An `issue` with `in_flight` at its maximum (all ones) and no `done` in the same cycle is ignored. It neither moves `in_flight` nor `req_count`, and it sets `seq_err`.
- R9: Bit g of `gpu_mask` selects GPU index g, with bit 0 selecting GPU 0. Strobes whose GPU index is not selected have no effect. An all-zero mask selects every GPU. With `peer_is_chip` at 1, the mask is not applied.
- R10: In an instance built with `IS_WRITE`=1, `peer_is_chip` at 1 makes all strobes ignored and holds every counter. In an instance built with `IS_WRITE`=0, `peer_is_chip` does not block counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Counting enable for the three counters |
| peer_is_chip | input | 1 | Far end of the link is another chip rather than GPUs |
| gpu_mask | input | NUM_GPU | Per-GPU select; all zeros means every GPU |
| issue | input | 1 | A request is issued this cycle |
| issue_gpu | input | GW | GPU index of the issued request |
| done | input | 1 | A request completes this cycle |
| done_gpu | input | GW | GPU index of the completing request |
| req_count | output | CNT_W | Accepted issues in counting cycles |
| cum_outs | output | CNT_W | Sum of outstanding count over counting cycles |
| cycle_count | output | CNT_W | Counting cycles elapsed |
| in_flight | output | OUT_W | Requests currently outstanding |
| seq_err | output | 1 | Sticky flag for an ignored underflow or overflow |

## Verification
The hardest state to reach is a full outstanding counter. Getting there needs 255 back-to-back issues with no completion, and only then can the overflow guard be tested. The bench drives that run directly from a clean reset, then adds one more issue.

Two other cases also need care. One is disabled counting while requests are still in flight. The bench issues a request, drops `enable`, issues another, and re-enables before the completion arrives. This shows that `in_flight` kept tracking while the other counters held. The other is a same-cycle issue and completion at zero outstanding, which is checked before any real underflow.

// File: rtl/outstanding_lat_acc.sv
module outstanding_lat_acc #(
  parameter int NUM_GPU  = 2,
  parameter int CNT_W    = 32,
  parameter int OUT_W    = 8,
  parameter bit IS_WRITE = 1'b0,
  localparam int GW = (NUM_GPU > 1) ? $clog2(NUM_GPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               peer_is_chip,
  input  logic [NUM_GPU-1:0] gpu_mask,
  input  logic               issue,
  input  logic [GW-1:0]      issue_gpu,
  input  logic               done,
  input  logic [GW-1:0]      done_gpu,
  output logic [CNT_W-1:0]   req_count,
  output logic [CNT_W-1:0]   cum_outs,
  output logic [CNT_W-1:0]   cycle_count,
  output logic [OUT_W-1:0]   in_flight,
  output logic               seq_err
);

  logic active, counting;
  logic iss_sel, done_sel, iss_v, done_v;
  logic at_max, at_zero, inc, dec, bad, iss_taken;

  assign active   = !(IS_WRITE && peer_is_chip);
  assign counting = enable && active;

  assign iss_sel  = peer_is_chip || (gpu_mask == '0) ||
                    (|(gpu_mask & (NUM_GPU'(1) << issue_gpu)));
  assign done_sel = peer_is_chip || (gpu_mask == '0) ||
                    (|(gpu_mask & (NUM_GPU'(1) << done_gpu)));

  assign iss_v  = active && issue && iss_sel;
  assign done_v = active && done && done_sel;

  assign at_max  = (in_flight == '1);
  assign at_zero = (in_flight == '0);

  assign inc       = iss_v && !done_v && !at_max;
  assign dec       = done_v && !iss_v && !at_zero;
  assign bad       = (iss_v && !done_v && at_max) || (done_v && !iss_v && at_zero);
  assign iss_taken = iss_v && (done_v || !at_max);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_flight   <= '0;
      seq_err     <= 1'b0;
      req_count   <= '0;
      cum_outs    <= '0;
      cycle_count <= '0;
    end else begin
      if (inc)      in_flight <= in_flight + 1'b1;
      else if (dec) in_flight <= in_flight - 1'b1;
      if (bad) seq_err <= 1'b1;
      if (counting) begin
        cycle_count <= cycle_count + 1'b1;
        cum_outs    <= cum_outs + CNT_W'(in_flight);
        if (iss_taken) req_count <= req_count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/outstanding_lat_acc_chk.sv
module outstanding_lat_acc_chk #(
  parameter int CNT_W = 32,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             active,
  input logic             issue,
  input logic [CNT_W-1:0] req_count,
  input logic [CNT_W-1:0] cum_outs,
  input logic [CNT_W-1:0] cycle_count,
  input logic [OUT_W-1:0] in_flight,
  input logic             seq_err
);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (in_flight == $past(in_flight)) ||
             (in_flight == OUT_W'($past(in_flight) + 1'b1)) ||
             (in_flight == OUT_W'($past(in_flight) - 1'b1)));

  p_accum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && active) |=> cum_outs == CNT_W'($past(cum_outs) + CNT_W'($past(in_flight))));

  p_cycles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && active) |=> cycle_count == CNT_W'($past(cycle_count) + 1'b1));

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && active) |=> $stable(req_count) && $stable(cum_outs) && $stable(cycle_count));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight == '0 && !issue) |=> in_flight == '0);

endmodule

bind outstanding_lat_acc outstanding_lat_acc_chk #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .active(active), .issue(issue),
  .req_count(req_count), .cum_outs(cum_outs), .cycle_count(cycle_count),
  .in_flight(in_flight), .seq_err(seq_err)
);

// File: tb/outstanding_lat_acc_bench.sv
`timescale 1ns/1ps
module outstanding_lat_acc_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic enable = 0, peer_is_chip = 0;
  logic [1:0] gpu_mask = '0;
  logic issue = 0, done = 0;
  logic [0:0] issue_gpu = '0, done_gpu = '0;
  logic [31:0] req_count, cum_outs, cycle_count;
  logic [31:0] w_req, w_cum, w_cyc;
  logic [7:0] in_flight, w_if;
  logic seq_err, w_err;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  outstanding_lat_acc #(.NUM_GPU(2), .CNT_W(32), .OUT_W(8), .IS_WRITE(1'b0)) u_outstanding_lat_acc (
    .clk(clk), .rst_n(rst_n), .enable(enable), .peer_is_chip(peer_is_chip),
    .gpu_mask(gpu_mask), .issue(issue), .issue_gpu(issue_gpu), .done(done),
    .done_gpu(done_gpu), .req_count(req_count), .cum_outs(cum_outs),
    .cycle_count(cycle_count), .in_flight(in_flight), .seq_err(seq_err));

  outstanding_lat_acc #(.NUM_GPU(2), .CNT_W(32), .OUT_W(8), .IS_WRITE(1'b1)) u_outstanding_lat_acc_wr (
    .clk(clk), .rst_n(rst_n), .enable(enable), .peer_is_chip(peer_is_chip),
    .gpu_mask(gpu_mask), .issue(issue), .issue_gpu(issue_gpu), .done(done),
    .done_gpu(done_gpu), .req_count(w_req), .cum_outs(w_cum),
    .cycle_count(w_cyc), .in_flight(w_if), .seq_err(w_err));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    enable = 0; peer_is_chip = 0; gpu_mask = '0;
    issue = 0; done = 0; issue_gpu = '0; done_gpu = '0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cyc(input logic i, input logic ig, input logic d, input logic dg);
    issue = i; issue_gpu = ig; done = d; done_gpu = dg;
    @(negedge clk);
    issue = 0; done = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 req_count", req_count, 0);
    chk("R1 cum_outs", cum_outs, 0);
    chk("R1 cycle_count", cycle_count, 0);
    chk("R1 in_flight", in_flight, 0);
    chk("R1 seq_err", seq_err, 0);
  endtask

  task automatic t_single();
    do_reset();
    enable = 1;
    cyc(1, 0, 0, 0);
    chk("R2 in_flight after issue", in_flight, 1);
    repeat (4) cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R3 cum_outs single latency 5", cum_outs, 5);
    chk("R4 req_count single", req_count, 1);
    chk("R5 cycle_count single", cycle_count, 6);
    chk("R2 in_flight after done", in_flight, 0);
  endtask

  task automatic t_overlap();
    do_reset();
    enable = 1;
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 0, 1, 0);
    chk("R2 in_flight same-cycle issue+done", in_flight, 2);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    chk("R3 cum_outs overlap", cum_outs, 6);
    chk("R4 req_count overlap", req_count, 3);
    chk("R5 cycle_count overlap", cycle_count, 5);
    chk("R2 in_flight drained", in_flight, 0);
  endtask

  task automatic t_disable();
    do_reset();
    enable = 1;
    cyc(1, 0, 0, 0);
    enable = 0;
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R6 req_count held", req_count, 1);
    chk("R6 cum_outs held", cum_outs, 0);
    chk("R6 cycle_count held", cycle_count, 1);
    chk("R6 in_flight tracks while disabled", in_flight, 2);
    enable = 1;
    cyc(0, 0, 1, 0);
    chk("R6 cum_outs resumes", cum_outs, 2);
    chk("R6 cycle_count resumes", cycle_count, 2);
    chk("R6 in_flight after done", in_flight, 1);
  endtask

  task automatic t_underflow();
    do_reset();
    enable = 1;
    cyc(1, 0, 1, 0);
    chk("R2 issue+done at zero in_flight", in_flight, 0);
    chk("R2 issue+done at zero no error", seq_err, 0);
    chk("R4 issue+done counted", req_count, 1);
    cyc(0, 0, 1, 0);
    chk("R7 underflow ignored", in_flight, 0);
    chk("R7 underflow flagged", seq_err, 1);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R7 flag sticky", seq_err, 1);
    chk("R7 counting continues", in_flight, 1);
  endtask

  task automatic t_overflow();
    do_reset();
    enable = 1;
    for (int k = 0; k < 255; k++) cyc(1, 0, 0, 0);
    chk("R8 in_flight full", in_flight, 255);
    chk("R8 no error at full", seq_err, 0);
    cyc(1, 0, 0, 0);
    chk("R8 overflow ignored in_flight", in_flight, 255);
    chk("R8 overflow ignored req_count", req_count, 255);
    chk("R8 overflow flagged", seq_err, 1);
  endtask

  task automatic t_mask();
    do_reset();
    enable = 1;
    gpu_mask = 2'b10;
    cyc(1, 0, 0, 0);
    chk("R9 unselected GPU0 issue ignored", req_count, 0);
    cyc(1, 1, 0, 0);
    chk("R9 GPU1 issue counted", req_count, 1);
    cyc(0, 0, 1, 0);
    chk("R9 unselected GPU0 done ignored", in_flight, 1);
    cyc(0, 0, 1, 1);
    chk("R9 GPU1 done taken", in_flight, 0);
    gpu_mask = 2'b00;
    cyc(1, 0, 0, 0);
    chk("R9 zero mask selects all", req_count, 2);
    gpu_mask = 2'b10;
    peer_is_chip = 1;
    cyc(1, 0, 0, 0);
    chk("R9 mask not applied for chip peer", req_count, 3);
    chk("R9 seq_err clear", seq_err, 0);
  endtask

  task automatic t_chip();
    do_reset();
    enable = 1;
    peer_is_chip = 1;
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R10 read instance counts", req_count, 2);
    chk("R10 read instance cum_outs", cum_outs, 3);
    chk("R10 write instance idle req", w_req, 0);
    chk("R10 write instance idle cycles", w_cyc, 0);
    chk("R10 write instance idle in_flight", w_if, 0);
    peer_is_chip = 0;
    cyc(1, 0, 0, 0);
    chk("R10 write instance active req", w_req, 1);
    chk("R10 write instance active cycles", w_cyc, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_overlap();
    t_disable();
    t_underflow();
    t_overflow();
    t_mask();
    t_chip();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule